// File: doc/BRIEF.md
# UART Receive Character Queue with Trigger Interrupt

This block stores received characters for a memory-mapped UART until software reads them through the data register. Each stored entry holds a data byte and four status bits: framing error, parity error, break, and overrun. Characters arrive on a single push port. Either the serial receiver or the internal loopback path drives that port. Each read of the data register drives the pop port. Reading takes the oldest entry and copies its status bits into a receive-status register. Software clears that register by writing any value to it.

The queue runs in one of two modes, and the mode can change at run time. With FIFO mode enabled it holds `DEPTH` entries (16 by default). With FIFO mode disabled it holds one character, like a holding register. Any change of the enable input empties the queue in the following cycle.

A three-state occupancy machine drives the flags. The states are `ST_EMPTY`, `ST_PART` and `ST_FULL`, and the transitions are:
- `T_FIRST`: `ST_EMPTY` to `ST_PART`.
- `T_FIRST_FULL`: `ST_EMPTY` to `ST_FULL`, the one-entry case.
- `T_FILL`: `ST_PART` to `ST_FULL`.
- `T_DRAIN`: `ST_PART` to `ST_EMPTY`.
- `T_UNFILL`: `ST_FULL` to `ST_PART`.
- `T_TAKE_ONLY`: `ST_FULL` to `ST_EMPTY`, the one-entry case.
- `T_FLUSH`: any state to `ST_EMPTY`.

The machine produces the empty flag, the full flag and a can-accept signal for the receiver. A separate raw receive interrupt bit follows the trigger level `TRIG_LEVEL`, which is 1 by default.

Top module: `rxq_buffer`

## Requirements
- R1: The capacity is `DEPTH` entries while `fifo_en` is 1 and one entry while `fifo_en` is 0. `can_accept` is 1 exactly when the stored count is below the capacity.
- R2: `fifo_empty` is 1 exactly when the count is 0, and `fifo_full` is 1 exactly when the count equals the capacity. After reset the block is empty, not full, and has `rx_irq`=0 and `rx_status`=0.
- R3: An accepted push writes slot (read position + count) modulo the capacity. Pops return entries in push order.
  - `pop_data` always shows the entry at the read position, formatted as [7:0] data byte, [8] framing, [9] parity, [10] break, [11] overrun.
  - `push_err` supplies bits [8], [9] and [10] as `push_err[0]`, `push_err[1]` and `push_err[2]`.
- R4: `rx_irq` becomes 1 on the clock edge of an accepted push that brings the count to `TRIG_LEVEL`.
- R5: `rx_irq` becomes 0 on the edge of a pop for which (count after the pop) + 1 equals `TRIG_LEVEL`. This includes a pop of an empty queue. A set in the same cycle takes priority over the clear.
- R6: A change of `fifo_en` from its value in the previous cycle flushes the queue: the next cycle has count 0 and read position 0.
  - A push or pop presented in that flush cycle has no effect.
  - `rx_irq` keeps its value across the flush.
- R7: A pop while the queue is empty leaves the count at 0 and the read position unchanged.
- R8: A cycle in which a push is accepted and a pop removes an entry leaves the count unchanged.
- R9: A pop loads `rx_status` with bits [11:8] of the popped entry: [0] framing, [1] parity, [2] break, [3] overrun. `status_clr` sets `rx_status` to 0, and a pop in the same cycle takes priority.
- R10: A push presented while the queue is full is dropped and latches an overrun marker. The next accepted entry carries bit [11]=1, and that acceptance clears the marker. A flush also clears the marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable level from the line control register |
| push_vld | input | 1 | Push request from the receiver or the loopback path |
| push_byte | input | 8 | Received data byte |
| push_err | input | 3 | Received status: [0] framing, [1] parity, [2] break |
| pop_req | input | 1 | Data register read strobe |
| status_clr | input | 1 | Write strobe to the receive-status register |
| pop_data | output | 12 | Entry at the read position (format in R3) |
| rx_status | output | 4 | Receive-status register (format in R9) |
| fifo_empty | output | 1 | Empty flag |
| fifo_full | output | 1 | Full flag |
| can_accept | output | 1 | Receiver may push |
| rx_irq | output | 1 | Raw receive interrupt bit |

## Verification
The embedded properties check the following on every clock:
- the one-entry bound in holding mode, and the read position staying at 0 in that mode;
- that the flags are mutually exclusive;
- that a flush empties the queue and leaves the interrupt unchanged;
- the unchanged count for a simultaneous push and pop, and for a pop of an empty queue;
- that the interrupt rises only after a push;
- the overrun latch and the status clear.

Other behaviours depend on values carried across many cycles, and only the bench's reference model can show them:
- ordering through pointer wrap-around;
- the overrun bit landing on the correct later entry;
- stale data shown by a pop of an empty queue;
- mode switches while the queue holds data.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DATA_W = 8;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rxq_err_t;

    typedef struct packed {
        rxq_err_t                err;
        logic [RXQ_DATA_W-1:0]   data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } rxq_fill_e;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1,
    parameter int CW         = $clog2(DEPTH + 1),
    parameter int PW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_vld,
    input  logic          pop_req,
    output logic          flush,
    output logic          push_ok,
    output logic          pop_act,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output logic [PW-1:0] slot_mask,
    output logic          fifo_empty,
    output logic          fifo_full,
    output logic          can_accept,
    output logic          rx_irq
);

    logic          en_q;
    logic [CW-1:0] depth_cur;
    logic [CW-1:0] cnt_after_pop;
    logic [CW-1:0] cnt_nxt;
    logic          irq_set;
    logic          irq_clr;
    rxq_fill_e     state_q;
    rxq_fill_e     state_d;

    assign flush     = fifo_en ^ en_q;
    assign depth_cur = en_q ? CW'(DEPTH) : CW'(1);
    assign slot_mask = en_q ? PW'(DEPTH - 1) : '0;

    assign push_ok = push_vld && !flush && (count < depth_cur);
    assign pop_act = pop_req && !flush;
    assign pop_ok  = pop_act && (count != '0);

    assign cnt_after_pop = count - CW'(pop_ok);
    assign cnt_nxt       = flush ? '0 : (cnt_after_pop + CW'(push_ok));

    assign irq_set = push_ok && ((int'(cnt_after_pop) + 1) == TRIG_LEVEL);
    assign irq_clr = pop_act && ((int'(cnt_after_pop) + 1) == TRIG_LEVEL);

    // Occupancy transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (flush)                       state_d = ST_EMPTY;
                else if (cnt_nxt == depth_cur)   state_d = ST_FULL;   // T_FIRST_FULL
                else if (cnt_nxt != '0)          state_d = ST_PART;   // T_FIRST
            end
            ST_PART: begin
                if (flush)                       state_d = ST_EMPTY;  // T_FLUSH
                else if (cnt_nxt == '0)          state_d = ST_EMPTY;  // T_DRAIN
                else if (cnt_nxt == depth_cur)   state_d = ST_FULL;   // T_FILL
            end
            ST_FULL: begin
                if (flush)                       state_d = ST_EMPTY;  // T_FLUSH
                else if (cnt_nxt == '0)          state_d = ST_EMPTY;  // T_TAKE_ONLY
                else if (cnt_nxt != depth_cur)   state_d = ST_PART;   // T_UNFILL
            end
            default:                             state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Flag outputs per state
    always_comb begin
        fifo_empty = 1'b0;
        fifo_full  = 1'b0;
        can_accept = 1'b1;
        unique case (state_q)
            ST_EMPTY: fifo_empty = 1'b1;
            ST_PART:  ;
            ST_FULL: begin
                fifo_full  = 1'b1;
                can_accept = 1'b0;
            end
            default:  fifo_empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            count  <= '0;
            rx_irq <= 1'b0;
        end else begin
            en_q  <= fifo_en;
            count <= cnt_nxt;
            if (irq_set)      rx_irq <= 1'b1;
            else if (irq_clr) rx_irq <= 1'b0;
        end
    end

    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (count <= CW'(1)));                                   // R1
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));                                    // R2
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(push_vld));                             // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && fifo_empty);                         // R6
    AST_FLUSH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(rx_irq));                                     // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_vld && !flush && fifo_empty) |=> fifo_empty); // R7
    AST_PAIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));                        // R8

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  rxq_entry_t    wr_entry,
    input  logic [CW-1:0] count,
    input  logic          pop_ok,
    input  logic [PW-1:0] slot_mask,
    output rxq_entry_t    head
);

    logic [PW-1:0] rd_pos;
    logic [PW-1:0] wr_slot;
    rxq_entry_t    slot_view [DEPTH];

    assign wr_slot = (rd_pos + count[PW-1:0]) & slot_mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rxq_entry_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= '0;
            else if (wr_en && (wr_slot == PW'(g)))    q <= wr_entry;
        end
        assign slot_view[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_pos <= '0;
        else if (flush)  rd_pos <= '0;
        else if (pop_ok) rd_pos <= (rd_pos + PW'(1)) & slot_mask;
    end

    assign head = slot_view[rd_pos];

    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mask == '0) |-> (rd_pos == '0));                          // R1
    AST_FLUSH_POS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_pos == '0));                                      // R6

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push_try,
    input  logic     push_ok,
    input  logic     pop_act,
    input  rxq_err_t head_err,
    input  logic     status_clr,
    output logic     ovr_pend,
    output rxq_err_t rx_status
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovr_pend <= 1'b0;
        else if (flush)    ovr_pend <= 1'b0;
        else if (push_ok)  ovr_pend <= 1'b0;
        else if (push_try) ovr_pend <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rx_status <= '0;
        else if (pop_act)    rx_status <= head_err;
        else if (status_clr) rx_status <= '0;
    end

    AST_OVR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && !push_ok) |=> ovr_pend);                           // R10
    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !pop_act) |=> (rx_status == '0));                // R9

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fifo_en,
    input  logic                    push_vld,
    input  logic [RXQ_DATA_W-1:0]   push_byte,
    input  logic [2:0]              push_err,
    input  logic                    pop_req,
    input  logic                    status_clr,
    output logic [RXQ_DATA_W+3:0]   pop_data,
    output logic [3:0]              rx_status,
    output logic                    fifo_empty,
    output logic                    fifo_full,
    output logic                    can_accept,
    output logic                    rx_irq
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);

    logic          flush;
    logic          push_ok;
    logic          pop_act;
    logic          pop_ok;
    logic [CW-1:0] count;
    logic [PW-1:0] slot_mask;
    logic          ovr_pend;
    rxq_entry_t    wr_entry;
    rxq_entry_t    head;
    rxq_err_t      stat;

    rxq_ctrl #(
        .DEPTH      (DEPTH),
        .TRIG_LEVEL (TRIG_LEVEL),
        .CW         (CW),
        .PW         (PW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_vld   (push_vld),
        .pop_req    (pop_req),
        .flush      (flush),
        .push_ok    (push_ok),
        .pop_act    (pop_act),
        .pop_ok     (pop_ok),
        .count      (count),
        .slot_mask  (slot_mask),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .can_accept (can_accept),
        .rx_irq     (rx_irq)
    );

    always_comb begin
        wr_entry.err.ovr = ovr_pend;
        wr_entry.err.brk = push_err[2];
        wr_entry.err.par = push_err[1];
        wr_entry.err.frm = push_err[0];
        wr_entry.data    = push_byte;
    end

    rxq_store #(
        .DEPTH (DEPTH),
        .CW    (CW),
        .PW    (PW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (push_ok),
        .wr_entry  (wr_entry),
        .count     (count),
        .pop_ok    (pop_ok),
        .slot_mask (slot_mask),
        .head      (head)
    );

    rxq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_try   (push_vld && !flush),
        .push_ok    (push_ok),
        .pop_act    (pop_act),
        .head_err   (head.err),
        .status_clr (status_clr),
        .ovr_pend   (ovr_pend),
        .rx_status  (stat)
    );

    assign pop_data  = head;
    assign rx_status = stat;

endmodule

// File: tb/rxq_buffer_bench.sv
`timescale 1ns/1ps
module rxq_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_vld = 1'b0;
    logic [7:0]  push_byte = '0;
    logic [2:0]  push_err = '0;
    logic        pop_req = 1'b0;
    logic        status_clr = 1'b0;
    logic [11:0] pop_data;
    logic [3:0]  rx_status;
    logic        fifo_empty, fifo_full, can_accept, rx_irq;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference model
    logic [11:0] m_mem [16];
    int          m_pos, m_cnt;
    logic        m_irq, m_ovr, m_en_q;
    logic [3:0]  m_stat;

    always #4 clk = ~clk;

    rxq_buffer u_rxq_buffer (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_vld(push_vld),
        .push_byte(push_byte), .push_err(push_err), .pop_req(pop_req),
        .status_clr(status_clr), .pop_data(pop_data), .rx_status(rx_status),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .can_accept(can_accept), .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mdepth();
        return m_en_q ? 16 : 1;
    endfunction

    task automatic compare_all();
        check("R3 pop_data",   pop_data,   m_mem[m_pos]);
        check("R9 rx_status",  rx_status,  m_stat);
        check("R2 fifo_empty", fifo_empty, m_cnt == 0);
        check("R2 fifo_full",  fifo_full,  m_cnt == mdepth());
        check("R1 can_accept", can_accept, m_cnt < mdepth());
        check("R4/R5 rx_irq",  rx_irq,     m_irq);
    endtask

    task automatic model_step(input logic en, input logic pv, input logic [7:0] pb,
                              input logic [2:0] pe, input logic pr, input logic sc);
        int  dep, msk, after;
        logic pok, rok, set_i, clr_i;
        if (en != m_en_q) begin
            // R6 flush
            m_cnt = 0; m_pos = 0; m_ovr = 1'b0;
            if (sc) m_stat = '0;
            m_en_q = en;
        end else begin
            dep   = mdepth();
            msk   = dep - 1;
            pok   = pv && (m_cnt < dep);
            rok   = pr && (m_cnt != 0);
            after = m_cnt - (rok ? 1 : 0);
            set_i = pok && (after + 1 == 1);
            clr_i = pr && (after + 1 == 1);
            if (pr)      m_stat = m_mem[m_pos][11:8];
            else if (sc) m_stat = '0;
            if (pok) m_mem[(m_pos + m_cnt) & msk] = {m_ovr, pe[2], pe[1], pe[0], pb};
            if (pok)     m_ovr = 1'b0;
            else if (pv) m_ovr = 1'b1;   // R10
            if (rok) m_pos = (m_pos + 1) & msk;
            m_cnt = after + (pok ? 1 : 0);
            if (set_i)      m_irq = 1'b1;
            else if (clr_i) m_irq = 1'b0;
        end
    endtask

    // drive at negedge, model after posedge, compare at next negedge
    task automatic cyc(input logic en, input logic pv, input logic [7:0] pb,
                       input logic [2:0] pe, input logic pr, input logic sc);
        fifo_en = en; push_vld = pv; push_byte = pb; push_err = pe;
        pop_req = pr; status_clr = sc;
        @(posedge clk);
        model_step(en, pv, pb, pe, pr, sc);
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(input logic en, input logic [7:0] b, input logic [2:0] e);
        cyc(en, 1'b1, b, e, 1'b0, 1'b0);
    endtask
    task automatic pop(input logic en);
        cyc(en, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    endtask
    task automatic idle(input logic en);
        cyc(en, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        logic        en_r;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_pos = 0; m_cnt = 0; m_irq = 0; m_ovr = 0; m_en_q = 0; m_stat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        check("R2 reset empty", fifo_empty, 1);
        check("R2 reset full",  fifo_full, 0);
        check("R2 reset irq",   rx_irq, 0);
        check("R2 reset status", rx_status, 0);
        compare_all();

        // enable FIFO mode: flush cycle (R6)
        idle(1'b1);
        check("R6 empty after enable", fifo_empty, 1);

        // R4 / R3 ordering
        push(1'b1, 8'hA1, 3'b000);
        check("R4 irq after first push", rx_irq, 1);
        push(1'b1, 8'hB2, 3'b000);
        push(1'b1, 8'hC3, 3'b000);
        check("R3 head A", pop_data, 12'h0A1);
        pop(1'b1);
        check("R3 head B", pop_data, 12'h0B2);
        check("R5 irq kept above trigger", rx_irq, 1);
        pop(1'b1);
        check("R3 head C", pop_data, 12'h0C3);
        pop(1'b1);
        check("R5 irq cleared", rx_irq, 0);
        check("R2 empty after drain", fifo_empty, 1);

        // R7 pop of empty queue
        pop(1'b1);
        check("R7 still empty", fifo_empty, 1);

        // R1 fill to capacity, R10 overrun
        for (int i = 0; i < 16; i++) push(1'b1, 8'(8'h10 + i), 3'b000);
        check("R1 full at 16", fifo_full, 1);
        check("R1 no accept at 16", can_accept, 0);
        push(1'b1, 8'hFF, 3'b000);
        check("R10 dropped, still full", fifo_full, 1);
        pop(1'b1);
        push(1'b1, 8'hEE, 3'b000);
        for (int i = 0; i < 15; i++) pop(1'b1);
        check("R10 overrun marked entry", pop_data, 12'h8EE);
        pop(1'b1);
        check("R9 status carries overrun", rx_status, 4'b1000);
        cyc(1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R9 status cleared", rx_status, 0);

        // R8 simultaneous push and pop
        push(1'b1, 8'h21, 3'b000);
        push(1'b1, 8'h22, 3'b000);
        cyc(1'b1, 1'b1, 8'h23, 3'b000, 1'b1, 1'b0);
        check("R8 head after pair", pop_data, 12'h022);
        pop(1'b1);
        check("R8 last entry", pop_data, 12'h023);
        pop(1'b1);
        check("R8 empty after two pops", fifo_empty, 1);

        // R9 error bits
        push(1'b1, 8'h5A, 3'b011);
        pop(1'b1);
        check("R9 framing+parity", rx_status, 4'b0011);

        // R6 switch to holding mode with data and irq pending, push in flush cycle
        push(1'b1, 8'h31, 3'b100);
        check("R4 irq before switch", rx_irq, 1);
        push(1'b0, 8'h32, 3'b000);
        check("R6 flushed", fifo_empty, 1);
        check("R6 irq kept", rx_irq, 1);
        pop(1'b0);
        check("R5 irq cleared by empty pop", rx_irq, 0);
        push(1'b0, 8'h41, 3'b000);
        check("R1 single full", fifo_full, 1);
        check("R1 single no accept", can_accept, 0);
        push(1'b0, 8'h42, 3'b000);
        check("R1 single head kept", pop_data, 12'h041);
        pop(1'b0);
        push(1'b0, 8'h43, 3'b000);
        check("R10 single overrun bit", pop_data, 12'h843);
        pop(1'b0);

        // pseudo-random traffic, model compare each cycle
        lf = 16'hACE1;
        en_r = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[7:0] == 8'h5C) en_r = ~en_r;
            cyc(en_r, lf[0] | lf[3], lf[15:8], lf[6:4], lf[1] & lf[9], lf[2] & lf[11] & lf[5]);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule